// File: doc/BRIEF.md
# Serial ADC Scan Host Sequencer

This block is the host side of a four-wire serial link to a multichannel analog-to-digital converter. The converter runs from its own internal conversion clock, uses 16-bit transfers and works in scan mode. A single `start` pulse runs one complete transaction. The block lowers chip select and sends a 16-clock command frame: one command byte followed by eight zero bits. It then parks the serial clock low. The clock stays low for a programmable quiet interval and until the converter signals end of conversion with a falling edge on its active-low ready line. After that the block clocks in one 16-bit result per scanned channel, MSB first.

Each result is offered on a valid/ready output together with the index of the channel it belongs to. The serial clock pauses while a result waits for the consumer. Chip select rises once the last result has been taken. Two static outputs hold the converter's interface-select pins at the levels that choose the four-wire serial mode.

The serial clock comes from the system clock through a parameterized divider. The end-of-conversion line is asynchronous to the system clock, so it passes through a synchronizer before its falling edge is detected.

Top module: `adc_scan_host`

## Requirements
- R1: After reset `cs_n` is 1, `sclk` is 0 and `res_valid` is 0. `ifmode_hi` is always 1 and `ifsel_lo` is always 0.
- R2: A `start` pulse while idle pulls `cs_n` low and produces exactly 16 `sclk` rising edges for the command frame. A `start` that arrives while a transaction is running is ignored.
- R3: The 16 bits on `mosi` at the command rising edges are `{scan_last[2:0], cfg_bits[4:0], 8'h00}`, sent MSB first. The channel field is therefore sampled by the third rising edge.
- R4: `mosi` changes only while `sclk` is low. It never changes between two system cycles in which `sclk` is high.
- R5: After the 16th command falling edge, `sclk` stays low for at least `QUIET_CYC + HALF_DIV` system cycles before the first readback rising edge. This holds even when end of conversion arrives early.
- R6: Readback starts only after a synchronized falling edge of `eoc_n`. No `sclk` edge occurs between the command frame and that falling edge.
- R7: Each result takes 16 `sclk` rising edges. `miso` is sampled at each rising edge and the bits are assembled MSB first into `res_data`.
- R8: A transaction returns `scan_last+1` results with `res_chan` equal to 0, 1, …, `scan_last`, in that order. It uses 16 command rising edges plus 16 rising edges per result.
- R9: While `res_valid` is 1 and `res_ready` is 0, `res_data` and `res_chan` hold steady and `sclk` stays low.
- R10: After the last result is accepted, `cs_n` returns to 1 and no further `sclk` edges occur until the next `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a transaction (used only while idle) |
| scan_last | input | 3 | Highest channel to scan; results come from channels 0..scan_last |
| cfg_bits | input | 5 | Remaining configuration bits of the command byte |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the converter |
| miso | input | 1 | Serial data from the converter |
| eoc_n | input | 1 | End-of-conversion strobe, active low, asynchronous |
| ifmode_hi | output | 1 | Static interface-mode select, tied high |
| ifsel_lo | output | 1 | Static interface select, tied low |
| res_valid | output | 1 | A result is available |
| res_ready | input | 1 | The consumer takes the result |
| res_data | output | 16 | Conversion result |
| res_chan | output | 3 | Channel index of the result |

## Verification
The hardest case to reach from the ports is an end-of-conversion edge that arrives while the quiet interval is still running. The block must remember that edge and still wait out the full interval before it restarts the clock. The bench's converter model lowers `eoc_n` with no delay after the command frame in a directed case and with short random delays elsewhere. It then measures the gap in system cycles to the first readback edge. Backpressure during readback is produced by a randomly throttled `res_ready`. A second `start`, sent with different fields in the middle of a command frame, shows that a running transaction cannot be disturbed.

// File: rtl/adc_scan_pkg.sv
// Shared types for the serial ADC scan host.
package adc_scan_pkg;
    // Sequencer phases of one transaction.
    typedef enum logic [2:0] {
        ST_IDLE,   // chip select high, waiting for start
        ST_CMD,    // shifting the 16-clock command frame
        ST_QUIET,  // clock parked, minimum quiet interval
        ST_WAIT,   // clock parked, waiting for end of conversion
        ST_READ,   // clocking in one result word
        ST_HOLD    // result offered, clock parked until taken
    } seq_state_t;
endpackage

// File: rtl/sclk_gen.sv
// Serial clock generator.
// Produces a 50% duty serial clock that starts in its low phase whenever
// 'run' is set. Each phase lasts HALF_DIV system cycles. rise_stb and
// fall_stb flag the system cycle at whose closing edge the clock goes
// high or low. Assumes 'run' comes from a register.
module sclk_gen #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk,
    output logic rise_stb,
    output logic fall_stb
);
    localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

    logic [CW-1:0] cnt;
    logic          sclk_q;
    logic          tick;

    // Phase end: the divider has reached its last count.
    always_comb begin
        tick     = run && (cnt == CW'(HALF_DIV - 1));
        rise_stb = tick && !sclk_q;
        fall_stb = tick && sclk_q;
    end

    // Divider count and clock level; both cleared while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt    <= '0;
            sclk_q <= 1'b0;
        end else if (tick) begin
            cnt    <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign sclk = sclk_q;

    // A stopped generator leaves the clock low.
    assert_stopped_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !sclk);
endmodule

// File: rtl/eoc_sync.sv
// End-of-conversion synchronizer.
// Brings the asynchronous active-low strobe into the system clock domain
// through two flops. A third flop detects the high-to-low transition.
// Emits a single-cycle pulse for each falling edge.
module eoc_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic eoc_n,
    output logic fall_stb
);
    logic s1, s2, s3;

    // Two-flop synchronizer followed by the edge history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
            s3 <= 1'b1;
        end else begin
            s1 <= eoc_n;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign fall_stb = s3 && !s2;

    // A detected edge never lasts more than one cycle.
    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |=> !fall_stb);
endmodule

// File: rtl/frame_shifter.sv
// MSB-first shift register.
// Loads in parallel when 'load' is set. Otherwise it shifts left by one
// and takes in_bit at the LSB when 'shift' is set. Load has priority.
module frame_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         in_bit,
    output logic [W-1:0] q
);
    // Parallel load or one-place shift.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (shift)
            q <= {q[W-2:0], in_bit};
    end
endmodule

// File: rtl/adc_scan_host.sv
// Serial ADC scan host sequencer (top).
// Runs one scan transaction per start pulse:
//   1. a 16-clock command frame,
//   2. a parked clock until the quiet interval has run out and end of
//      conversion has been seen,
//   3. scan_last+1 result words of WORD_W bits each.
// Every word is offered on a valid/ready port with its channel index.
// Assumes QUIET_CYC >= 1, CMD_W > CH_W and a converter that updates its
// data line on serial clock falling edges.
module adc_scan_host
    import adc_scan_pkg::*;
#(
    parameter int HALF_DIV  = 2,
    parameter int QUIET_CYC = 8,
    parameter int WORD_W    = 16,
    parameter int CMD_W     = 8,
    parameter int CH_W      = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CH_W-1:0]   scan_last,
    input  logic [CMD_W-CH_W-1:0] cfg_bits,
    output logic              cs_n,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    input  logic              eoc_n,
    output logic              ifmode_hi,
    output logic              ifsel_lo,
    output logic              res_valid,
    input  logic              res_ready,
    output logic [WORD_W-1:0] res_data,
    output logic [CH_W-1:0]   res_chan
);
    localparam int FRAME_W = 2 * CMD_W;
    localparam int CNT_MAX = (FRAME_W > WORD_W) ? FRAME_W : WORD_W;
    localparam int BC_W    = $clog2(CNT_MAX);
    localparam int QW      = $clog2(QUIET_CYC + 1);

    seq_state_t       state;
    logic [BC_W-1:0]  bit_cnt;
    logic [QW-1:0]    quiet_cnt;
    logic             eoc_seen;
    logic [CH_W-1:0]  word_idx;
    logic [CH_W-1:0]  last_q;

    logic             run, rise_stb, fall_stb, eoc_fall;
    logic             tx_load, tx_shift, rx_shift;
    logic [FRAME_W-1:0] tx_q;
    logic [WORD_W-1:0]  rx_q;

    // Control strobes derived from the registered phase.
    always_comb begin
        run      = (state == ST_CMD) || (state == ST_READ);
        tx_load  = (state == ST_IDLE) && start;
        tx_shift = (state == ST_CMD) && fall_stb;
        rx_shift = (state == ST_READ) && rise_stb;
    end

    sclk_gen #(.HALF_DIV(HALF_DIV)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(run),
        .sclk(sclk), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    eoc_sync u_eoc (
        .clk(clk), .rst_n(rst_n), .eoc_n(eoc_n), .fall_stb(eoc_fall)
    );

    frame_shifter #(.W(FRAME_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(tx_load),
        .load_val({scan_last, cfg_bits, {CMD_W{1'b0}}}),
        .shift(tx_shift), .in_bit(1'b0), .q(tx_q)
    );

    frame_shifter #(.W(WORD_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .load(1'b0), .load_val('0),
        .shift(rx_shift), .in_bit(miso), .q(rx_q)
    );

    // Transaction sequencer: phase, bit, quiet and word counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            bit_cnt   <= '0;
            quiet_cnt <= '0;
            eoc_seen  <= 1'b0;
            word_idx  <= '0;
            last_q    <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    last_q   <= scan_last;
                    word_idx <= '0;
                    bit_cnt  <= '0;
                    state    <= ST_CMD;
                end
                ST_CMD: if (fall_stb) begin
                    if (bit_cnt == BC_W'(FRAME_W - 1)) begin
                        bit_cnt   <= '0;
                        quiet_cnt <= '0;
                        eoc_seen  <= 1'b0;
                        state     <= ST_QUIET;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_QUIET: begin
                    if (eoc_fall)
                        eoc_seen <= 1'b1;
                    if (quiet_cnt == QW'(QUIET_CYC - 1))
                        state <= (eoc_seen || eoc_fall) ? ST_READ : ST_WAIT;
                    else
                        quiet_cnt <= quiet_cnt + 1'b1;
                end
                ST_WAIT: if (eoc_fall)
                    state <= ST_READ;
                ST_READ: if (fall_stb) begin
                    if (bit_cnt == BC_W'(WORD_W - 1)) begin
                        bit_cnt <= '0;
                        state   <= ST_HOLD;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_HOLD: if (res_ready) begin
                    if (word_idx == last_q) begin
                        state <= ST_IDLE;
                    end else begin
                        word_idx <= word_idx + 1'b1;
                        state    <= ST_READ;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port outputs.
    assign cs_n      = (state == ST_IDLE);
    assign mosi      = tx_q[FRAME_W-1];
    assign res_valid = (state == ST_HOLD);
    assign res_data  = rx_q;
    assign res_chan  = word_idx;
    assign ifmode_hi = 1'b1;
    assign ifsel_lo  = 1'b0;

    // The serial clock only runs under an asserted chip select.
    assert_sclk_under_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> !cs_n);

    // Command data is steady across each high phase.
    assert_mosi_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |=> (!sclk || $stable(mosi)));

    // The clock is parked during the quiet and wait phases.
    assert_quiet_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_QUIET || state == ST_WAIT) |-> !sclk);

    // An offered result is held unchanged until taken.
    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_chan)));

    // Taking the last word releases chip select.
    assert_cs_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ready && res_chan == last_q) |=> cs_n);
endmodule

// File: tb/tb_adc_scan_host.sv
// Self-checking bench with a behavioural converter model.
module tb_adc_scan_host;
    localparam int HALF_DIV  = 2;
    localparam int QUIET_CYC = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  scan_last = '0;
    logic [4:0]  cfg_bits = '0;
    logic        cs_n, sclk, mosi, ifmode_hi, ifsel_lo, res_valid;
    logic        miso = 1'b0;
    logic        eoc_n = 1'b1;
    logic        res_ready = 1'b0;
    logic [15:0] res_data;
    logic [2:0]  res_chan;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // Converter model and scoreboard state.
    logic [15:0] dev_words [0:7];
    logic [15:0] dev_frame;
    int          dev_n = 1;
    int          eoc_delay = 0;
    int          ready_pct = 100;
    int          rise_total = 0;
    int          rises_at_eoc = 0;
    int          t_cmd_end = 0;
    int          t_read_first = 0;
    bit          dev_done = 0;
    int          rx_idx = 0;
    bit          hold_pending = 0;
    logic [15:0] hold_data;
    logic [2:0]  hold_chan;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    adc_scan_host #(.HALF_DIV(HALF_DIV), .QUIET_CYC(QUIET_CYC)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .scan_last(scan_last),
        .cfg_bits(cfg_bits), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .miso(miso), .eoc_n(eoc_n), .ifmode_hi(ifmode_hi), .ifsel_lo(ifsel_lo),
        .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
        .res_chan(res_chan)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_frame(input logic [2:0] sl, input logic [4:0] cf);
        return {sl, cf, 8'h00};
    endfunction

    always @(posedge sclk) rise_total++;

    // Converter model: capture the command, signal conversion end, send words.
    initial begin
        forever begin
            @(negedge cs_n);
            miso = 1'b0;
            dev_frame = '0;
            for (int i = 0; i < 16; i++) begin
                @(posedge sclk);
                dev_frame = {dev_frame[14:0], mosi};
            end
            @(negedge sclk);
            t_cmd_end = cyc;
            repeat (eoc_delay) @(negedge clk);
            @(negedge clk);
            rises_at_eoc = rise_total;
            eoc_n = 1'b0;
            miso = dev_words[0][15];
            for (int w = 0; w < dev_n; w++) begin
                for (int b = 15; b >= 0; b--) begin
                    @(posedge sclk);
                    if (w == 0 && b == 15) t_read_first = cyc;
                    @(negedge sclk);
                    if (b > 0) miso = dev_words[w][b-1];
                    else if (w < dev_n - 1) miso = dev_words[w+1][15];
                end
            end
            @(posedge cs_n);
            eoc_n = 1'b1;
            miso = 1'b0;
            dev_done = 1;
        end
    end

    // Consumer: random ready, data/channel order and hold checks.
    always @(negedge clk) begin
        res_ready = (($urandom % 100) < ready_pct);
        if (rst_n && hold_pending && res_valid) begin
            check(res_data == hold_data && res_chan == hold_chan, "R9", "held result changed",
                  res_data, hold_data);
            check(!sclk, "R9", "sclk ran during hold", sclk, 0);
        end
        if (rst_n && res_valid && res_ready) begin
            check(res_data == dev_words[rx_idx[2:0]], "R7", "result word", res_data, dev_words[rx_idx[2:0]]);
            check(res_chan == 3'(rx_idx), "R8", "channel tag", res_chan, rx_idx);
            rx_idx++;
            hold_pending = 0;
        end else if (rst_n && res_valid) begin
            hold_data = res_data;
            hold_chan = res_chan;
            hold_pending = 1;
        end else begin
            hold_pending = 0;
        end
    end

    task automatic run_txn(input logic [2:0] sl, input logic [4:0] cf, input int dly,
                           input int rpct, input bit poke);
        int base;
        dev_n = int'(sl) + 1;
        eoc_delay = dly;
        ready_pct = rpct;
        rise_total = 0;
        rx_idx = 0;
        dev_done = 0;
        @(negedge clk);
        scan_last = sl;
        cfg_bits = cf;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (10) @(negedge clk);
            scan_last = ~sl;
            cfg_bits = ~cf;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait (dev_done);
        check(dev_frame == exp_frame(sl, cf), poke ? "R2" : "R3", "command frame",
              dev_frame, exp_frame(sl, cf));
        check(rises_at_eoc == 16, "R6", "edges before end of conversion", rises_at_eoc, 16);
        check(t_read_first - t_cmd_end >= QUIET_CYC + HALF_DIV, "R5", "quiet gap",
              t_read_first - t_cmd_end, QUIET_CYC + HALF_DIV);
        check(rx_idx == dev_n, "R8", "result count", rx_idx, dev_n);
        check(rise_total == 16 + 16 * dev_n, "R8", "total sclk rises", rise_total, 16 + 16 * dev_n);
        base = rise_total;
        repeat (20) @(negedge clk);
        check(cs_n == 1'b1 && rise_total == base, "R10", "idle after last word", rise_total, base);
    endtask

    // Watchdog: a hung run is a failure.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=0", cyc);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1168));
        for (int i = 0; i < 8; i++) dev_words[i] = 16'h0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cs_n == 1'b1, "R1", "cs_n after reset", cs_n, 1);
        check(sclk == 1'b0, "R1", "sclk after reset", sclk, 0);
        check(res_valid == 1'b0, "R1", "res_valid after reset", res_valid, 0);
        check(ifmode_hi == 1'b1, "R1", "ifmode_hi level", ifmode_hi, 1);
        check(ifsel_lo == 1'b0, "R1", "ifsel_lo level", ifsel_lo, 0);

        // Directed: one channel, end of conversion at once (quiet corner R5).
        dev_words[0] = 16'hFFFF;
        run_txn(3'd0, 5'h15, 0, 100, 0);

        // Directed: full scan, late end of conversion, all-zero and pattern words.
        for (int i = 0; i < 8; i++) dev_words[i] = (i % 2 == 0) ? 16'h0000 : 16'hA5C3 ^ 16'(i);
        run_txn(3'd7, 5'h0A, 40, 100, 0);

        // Directed: start during the command frame is ignored (R2).
        for (int i = 0; i < 8; i++) dev_words[i] = 16'($urandom);
        run_txn(3'd2, 5'h1F, 5, 60, 1);

        // Random transactions with backpressure.
        for (int t = 0; t < 8; t++) begin
            for (int i = 0; i < 8; i++) dev_words[i] = 16'($urandom);
            run_txn(3'($urandom), 5'($urandom), int'($urandom % 30), 30 + int'($urandom % 71), 0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule